// File: doc/BRIEF.md
# Bus Bridge Address Window Translator

This block holds eight programmable address windows that map addresses seen on one bus onto another bus. Each window has four 32-bit words: a control word, a start address, a bound address and an offset. Software sets them up through a single-word write/read configuration port. The windows are split into two groups of four. Each group has its own base in the configuration space, and within a group the windows sit five words apart.

A lookup presents an address, an address-space code and two access-mode flags (program and supervisor), together with a direction bit. In the reverse direction the block tests whether the address falls inside a window and adds that window's offset. In the forward direction it first subtracts the offset and then tests the range. The result is registered and appears one clock after the request. It carries a hit flag, the translated address and the index of the window that won.

Low-order bits of start, bound and offset are ignored. Windows 0 and 4 use 4 KB granularity and the other windows use 64 KB granularity, so software can place the first window of each group more finely.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window word reads 0, `rsp_valid` and `rsp_hit` are 0, and a lookup misses.
- R2: Window w of 0..3 occupies word addresses 5w+k, and window w of 4..7 occupies 32+5(w-4)+k. The field k is 0 for control, 1 for start, 2 for bound and 3 for offset. Word k=4 of each window, and every address outside these blocks, reads 0 and ignores writes. Read data appears one clock after the address is presented and returns the raw stored value.
- R3: Control bit 31 enables a window. A window whose bit 31 is 0 never matches.
- R4: Control bits 18:16 hold the address-space code (0 = 16-bit, 1 = 24-bit, 2 = 32-bit). Control bit 14 is the program flag and bit 12 is the supervisor flag. A window matches only when all three agree exactly with `lk_space`, `lk_prog` and `lk_super`. A request space code of 3 or above never matches.
- R5: Before use, start, bound and offset have their low 12 bits cleared for windows 0 and 4, and their low 16 bits cleared for windows 1, 2, 3, 5, 6 and 7.
- R6: Reverse (`lk_reverse`=1): the window hits when start <= address < bound, and the result is address + offset modulo 2^32.
- R7: Forward (`lk_reverse`=0): x = address - offset modulo 2^32. The window hits when start <= x < bound, and the result is x.
- R8: When several windows match, the lowest index wins and its index is output on `rsp_win`.
- R9: On a miss, `rsp_hit` is 0, `rsp_addr` equals the request address and `rsp_win` is 0.
- R10: `rsp_valid` is 1 exactly one clock after a cycle with `lk_req`=1 and is 0 otherwise. A lookup uses the window contents from before any write made in the same cycle, and a write affects lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the address of the previous cycle |
| lk_req | input | 1 | Lookup request |
| lk_reverse | input | 1 | 1 = reverse (add offset), 0 = forward (subtract offset) |
| lk_addr | input | 32 | Address to translate |
| lk_space | input | 3 | Requested address-space code |
| lk_prog | input | 1 | Requested program-access flag |
| lk_super | input | 1 | Requested supervisor flag |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_addr | output | 32 | Translated address, or the request address on a miss |

## Verification
A corrupted window word shows at the ports in two ways. On the next readback of that word it appears on `cfg_rdata` one clock after the address is presented. On the first lookup that falls in the affected range, the response one clock later carries a wrong hit flag, window index or translated address. A wrong granularity mask only shows when an address lands in the strip between the masked and raw boundary, so the vectors sit exactly on those edges. A priority fault shows only for addresses inside overlapping windows. A fault in the mode compare shows only for requests whose space or flags differ from a window by a single field.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned EN_BIT    = 31;
    localparam int unsigned SPACE_LSB = 16;
    localparam int unsigned SPACE_MSB = 18;
    localparam int unsigned PROG_BIT  = 14;
    localparam int unsigned SUPER_BIT = 12;

    localparam int F_CTRL  = 0;
    localparam int F_START = 1;
    localparam int F_BOUND = 2;
    localparam int F_OFFS  = 3;
    localparam int F_USED  = 4;

    typedef enum logic [2:0] {
        SP_A16 = 3'd0,
        SP_A24 = 3'd1,
        SP_A32 = 3'd2
    } space_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] start;
        logic [WORD_W-1:0] bound;
        logic [WORD_W-1:0] offs;
    } win_regs_t;

    typedef struct packed {
        logic [2:0] space;
        logic       prog;
        logic       sup;
    } mode_t;

    function automatic logic space_valid(input logic [2:0] s);
        return (s == SP_A16) || (s == SP_A24) || (s == SP_A32);
    endfunction

endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile
    import xlt_pkg::*;
#(
    parameter int NWIN      = 8,
    parameter int GRP_SIZE  = 4,
    parameter int STRIDE    = 5,
    parameter int GRP0_BASE = 0,
    parameter int GRP1_BASE = 32,
    parameter int CA_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output win_regs_t         regs_o [NWIN]
);

    typedef struct packed {
        win_regs_t [NWIN-1:0] win;
        logic [WORD_W-1:0]    rdata;
    } state_t;

    state_t state_d, state_q;

    function automatic int win_base(input int w);
        if (w < GRP_SIZE) begin
            return GRP0_BASE + w * STRIDE;
        end
        return GRP1_BASE + (w - GRP_SIZE) * STRIDE;
    endfunction

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        for (int w = 0; w < NWIN; w++) begin
            int rel;
            rel = int'(cfg_addr) - win_base(w);
            if (rel >= 0 && rel < F_USED) begin
                case (rel)
                    F_CTRL:  state_d.rdata = state_q.win[w].ctrl;
                    F_START: state_d.rdata = state_q.win[w].start;
                    F_BOUND: state_d.rdata = state_q.win[w].bound;
                    default: state_d.rdata = state_q.win[w].offs;
                endcase
                if (cfg_we) begin
                    case (rel)
                        F_CTRL:  state_d.win[w].ctrl  = cfg_wdata;
                        F_START: state_d.win[w].start = cfg_wdata;
                        F_BOUND: state_d.win[w].bound = cfg_wdata;
                        default: state_d.win[w].offs  = cfg_wdata;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_rdata = state_q.rdata;

    for (genvar g = 0; g < NWIN; g++) begin : g_out
        assign regs_o[g] = state_q.win[g];
    end

    // R2: window contents change only in the cycle after a write strobe
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(state_q.win));

endmodule

// File: rtl/xlt_window.sv
module xlt_window
    import xlt_pkg::*;
#(
    parameter int GRAN_BITS = 16
) (
    input  win_regs_t         regs_i,
    input  logic [WORD_W-1:0] lk_addr,
    input  mode_t             lk_mode,
    input  logic              lk_reverse,
    output logic              match_o,
    output logic [WORD_W-1:0] xaddr_o
);

    localparam logic [WORD_W-1:0] MASK = ~((WORD_W'(1) << GRAN_BITS) - WORD_W'(1));

    logic [WORD_W-1:0] start_m, bound_m, offs_m, cand;
    logic              mode_ok, in_range;
    logic              unused_ctrl;

    assign unused_ctrl = ^{regs_i.ctrl[EN_BIT-1:SPACE_MSB+1], regs_i.ctrl[SPACE_LSB-1:PROG_BIT+1],
                           regs_i.ctrl[PROG_BIT-1:SUPER_BIT+1], regs_i.ctrl[SUPER_BIT-1:0]};

    always_comb begin
        start_m  = regs_i.start & MASK;
        bound_m  = regs_i.bound & MASK;
        offs_m   = regs_i.offs & MASK;
        cand     = lk_reverse ? lk_addr : (lk_addr - offs_m);
        in_range = (cand >= start_m) && (cand < bound_m);
        mode_ok  = (regs_i.ctrl[SPACE_MSB:SPACE_LSB] == lk_mode.space)
                && (regs_i.ctrl[PROG_BIT] == lk_mode.prog)
                && (regs_i.ctrl[SUPER_BIT] == lk_mode.sup)
                && space_valid(lk_mode.space);
        match_o  = regs_i.ctrl[EN_BIT] && mode_ok && in_range;
        xaddr_o  = lk_reverse ? (lk_addr + offs_m) : cand;
    end

endmodule

// File: rtl/xlt_select.sv
module xlt_select
    import xlt_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int WIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [WORD_W-1:0] lk_addr,
    input  logic [NWIN-1:0]   match_i,
    input  logic [WORD_W-1:0] xaddr_i [NWIN],
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [WORD_W-1:0] rsp_addr
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [WORD_W-1:0] addr;
    } resp_t;

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d       = '0;
        resp_d.valid = lk_req;
        resp_d.addr  = lk_addr;
        if (lk_req) begin
            for (int w = NWIN - 1; w >= 0; w--) begin
                if (match_i[w]) begin
                    resp_d.hit  = 1'b1;
                    resp_d.win  = WIN_W'(w);
                    resp_d.addr = xaddr_i[w];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid = resp_q.valid;
    assign rsp_hit   = resp_q.hit;
    assign rsp_win   = resp_q.win;
    assign rsp_addr  = resp_q.addr;

    // R10: a response follows every request, and only requests
    a_r10_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R9: a request no window claims passes its address through unchanged
    a_r9_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (match_i == '0)) |=> (!rsp_hit && rsp_addr == $past(lk_addr) && rsp_win == '0));

    // R8: no window below the reported one matched the request
    a_r8_no_lower_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (($past(match_i) & ((NWIN'(1) << rsp_win) - NWIN'(1))) == '0));

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xlt_pkg::*;
#(
    parameter int NWIN        = 8,
    parameter int GRP_SIZE    = 4,
    parameter int STRIDE      = 5,
    parameter int GRP0_BASE   = 0,
    parameter int GRP1_BASE   = 32,
    parameter int CA_W        = 6,
    parameter int FINE_BITS   = 12,
    parameter int COARSE_BITS = 16,
    localparam int WIN_W      = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              lk_req,
    input  logic              lk_reverse,
    input  logic [31:0]       lk_addr,
    input  logic [2:0]        lk_space,
    input  logic              lk_prog,
    input  logic              lk_super,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [31:0]       rsp_addr
);

    win_regs_t         regs [NWIN];
    logic [NWIN-1:0]   match;
    logic [WORD_W-1:0] xaddr [NWIN];
    mode_t             mode;

    assign mode = '{space: lk_space, prog: lk_prog, sup: lk_super};

    xlt_regfile #(
        .NWIN(NWIN), .GRP_SIZE(GRP_SIZE), .STRIDE(STRIDE),
        .GRP0_BASE(GRP0_BASE), .GRP1_BASE(GRP1_BASE), .CA_W(CA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .regs_o(regs)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int GRAN = ((w % GRP_SIZE) == 0) ? FINE_BITS : COARSE_BITS;
        xlt_window #(.GRAN_BITS(GRAN)) u_win (
            .regs_i(regs[w]), .lk_addr(lk_addr), .lk_mode(mode),
            .lk_reverse(lk_reverse), .match_o(match[w]), .xaddr_o(xaddr[w])
        );
    end

    xlt_select #(.NWIN(NWIN), .WIN_W(WIN_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .match_i(match), .xaddr_i(xaddr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    // Views of the register bank used to check the response against it
    logic [NWIN-1:0] en_vec, space_eq_vec;
    always_comb begin
        for (int w = 0; w < NWIN; w++) begin
            en_vec[w]       = regs[w].ctrl[EN_BIT];
            space_eq_vec[w] = (regs[w].ctrl[SPACE_MSB:SPACE_LSB] == lk_space) && space_valid(lk_space);
        end
    end

    // R3: a reported window was enabled in the request cycle
    a_r3_hit_window_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ((($past(en_vec) >> rsp_win) & NWIN'(1)) != '0));

    // R4: a reported window carried the requested, valid space code
    a_r4_hit_space_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> ((($past(space_eq_vec) >> rsp_win) & NWIN'(1)) != '0));

endmodule

// File: tb/sim_addr_window_xlate.sv
`timescale 1ns/1ps
module sim_addr_window_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        lk_req, lk_reverse, lk_prog, lk_super;
    logic [31:0] lk_addr;
    logic [2:0]  lk_space;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_win;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    addr_window_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req),
        .lk_reverse(lk_reverse), .lk_addr(lk_addr), .lk_space(lk_space),
        .lk_prog(lk_prog), .lk_super(lk_super), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic        rev;
        logic [2:0]  sp;
        logic        pg;
        logic        su;
        logic [31:0] a;
        logic        hit;
        logic [2:0]  win;
        logic [31:0] ea;
    } vec_t;

    // rev, space, prog, super, address, expected hit, window, address
    localparam vec_t VT [15] = '{
        '{1'b1, 3'd1, 1'b0, 1'b0, 32'h0010_0000, 1'b1, 3'd0, 32'h1010_0000}, // R6 R5 start mask
        '{1'b1, 3'd1, 1'b0, 1'b0, 32'h0010_1FFF, 1'b1, 3'd0, 32'h1010_1FFF}, // R6 top
        '{1'b1, 3'd1, 1'b0, 1'b0, 32'h0010_2000, 1'b0, 3'd0, 32'h0010_2000}, // R5 bound mask
        '{1'b1, 3'd1, 1'b0, 1'b0, 32'h000F_FFFF, 1'b0, 3'd0, 32'h000F_FFFF}, // R9 below
        '{1'b1, 3'd2, 1'b1, 1'b1, 32'h2800_0000, 1'b1, 3'd1, 32'h1800_0000}, // R6 wrap
        '{1'b1, 3'd2, 1'b1, 1'b0, 32'h2800_0000, 1'b0, 3'd0, 32'h2800_0000}, // R4 flag
        '{1'b1, 3'd2, 1'b0, 1'b0, 32'h4000_8000, 1'b1, 3'd2, 32'h4000_8000}, // R8 R5 offset
        '{1'b1, 3'd2, 1'b0, 1'b0, 32'h4001_0000, 1'b1, 3'd5, 32'h4101_0000}, // R8 group 2
        '{1'b1, 3'd2, 1'b0, 1'b0, 32'h6000_0000, 1'b0, 3'd0, 32'h6000_0000}, // R3 disabled
        '{1'b0, 3'd1, 1'b0, 1'b0, 32'h1010_0800, 1'b1, 3'd0, 32'h0010_0800}, // R7
        '{1'b0, 3'd2, 1'b1, 1'b1, 32'h1000_0000, 1'b1, 3'd1, 32'h2000_0000}, // R7 wrap
        '{1'b0, 3'd0, 1'b0, 1'b0, 32'h0000_6000, 1'b1, 3'd4, 32'h0000_1000}, // R5 fine win4
        '{1'b0, 3'd0, 1'b0, 1'b0, 32'h0000_8000, 1'b0, 3'd0, 32'h0000_8000}, // R7 at bound
        '{1'b1, 3'd3, 1'b0, 1'b0, 32'h0000_1000, 1'b0, 3'd0, 32'h0000_1000}, // R4 invalid
        '{1'b1, 3'd0, 1'b0, 1'b0, 32'h0000_2FFF, 1'b1, 3'd4, 32'h0000_7FFF}  // R6 A16
    };

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rsp(input string req, input logic h, input logic [2:0] w, input logic [31:0] a);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_win !== w || rsp_addr !== a) begin
            n_bad++;
            $display("FAIL %s actual=v%b h%b w%0d %h expected=v1 h%b w%0d %h",
                     req, rsp_valid, rsp_hit, rsp_win, rsp_addr, h, w, a);
        end
    endtask

    task automatic wr(input logic [5:0] ad, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] ad, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = ad;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic lookup(input logic rv, input logic [2:0] sp, input logic pg,
                          input logic su, input logic [31:0] a);
        @(negedge clk);
        lk_req = 1'b1; lk_reverse = rv; lk_space = sp; lk_prog = pg; lk_super = su; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        lk_req = 1'b0; lk_reverse = 1'b0; lk_addr = '0; lk_space = '0; lk_prog = 1'b0; lk_super = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk32("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rd(6'd0, d);
        chk32("R1 ctrl0", d, 32'd0);
        lookup(1'b1, 3'd0, 1'b0, 1'b0, 32'h0000_0000);
        chk_rsp("R1 lookup miss", 1'b0, 3'd0, 32'h0000_0000);

        // configuration
        wr(6'd0,  32'h8001_0000); wr(6'd1,  32'h0010_0123); wr(6'd2,  32'h0010_2FFF); wr(6'd3,  32'h1000_0000);
        wr(6'd5,  32'h8002_5000); wr(6'd6,  32'h2000_0000); wr(6'd7,  32'h3000_0000); wr(6'd8,  32'hF000_0000);
        wr(6'd10, 32'h8002_0000); wr(6'd11, 32'h4000_0000); wr(6'd12, 32'h4001_8000); wr(6'd13, 32'h0000_1234);
        wr(6'd15, 32'h0002_0000); wr(6'd16, 32'h0000_0000); wr(6'd17, 32'hFFFF_0000); wr(6'd18, 32'h0000_0000);
        wr(6'd32, 32'h8000_0000); wr(6'd33, 32'h0000_1000); wr(6'd34, 32'h0000_3000); wr(6'd35, 32'h0000_5000);
        wr(6'd37, 32'h8002_0000); wr(6'd38, 32'h4000_0000); wr(6'd39, 32'h5000_0000); wr(6'd40, 32'h0100_0000);
        wr(6'd42, 32'h8003_0000); wr(6'd43, 32'h0000_0000); wr(6'd44, 32'hFFFF_0000); wr(6'd45, 32'h0000_0000);
        wr(6'd20, 32'hDEAD_BEEF); wr(6'd9, 32'hCAFE_0001);

        // R2: register map and readback
        rd(6'd1, d);  chk32("R2 w0 start raw", d, 32'h0010_0123);
        rd(6'd39, d); chk32("R2 w5 bound", d, 32'h5000_0000);
        rd(6'd8, d);  chk32("R2 w1 offset", d, 32'hF000_0000);
        rd(6'd9, d);  chk32("R2 reserved word", d, 32'd0);
        rd(6'd20, d); chk32("R2 unmapped word", d, 32'd0);
        rd(6'd32, d); chk32("R2 w4 ctrl", d, 32'h8000_0000);

        // R3..R9: vector table
        for (int i = 0; i < 15; i++) begin
            lookup(VT[i].rev, VT[i].sp, VT[i].pg, VT[i].su, VT[i].a);
            chk_rsp($sformatf("R3-9 vector %0d", i), VT[i].hit, VT[i].win, VT[i].ea);
        end

        // R10: valid drops without a request
        @(negedge clk);
        chk32("R10 valid low", {31'd0, rsp_valid}, 32'd0);

        // R10: write and lookup in the same cycle see the old contents
        wr(6'd48, 32'h7000_0000); wr(6'd49, 32'h7100_0000); wr(6'd50, 32'h0000_0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd47; cfg_wdata = 32'h8001_0000;
        lk_req = 1'b1; lk_reverse = 1'b1; lk_space = 3'd1; lk_prog = 1'b0; lk_super = 1'b0; lk_addr = 32'h7000_0000;
        @(negedge clk);
        cfg_we = 1'b0; lk_req = 1'b0;
        chk_rsp("R10 same-cycle write unseen", 1'b0, 3'd0, 32'h7000_0000);
        lookup(1'b1, 3'd1, 1'b0, 1'b0, 32'h7000_0000);
        chk_rsp("R10 write seen next", 1'b1, 3'd7, 32'h7000_0000);

        done = 1'b1;
        finish_run();
    end

endmodule